// File: doc/BRIEF.md
# Reference-Gated Frequency Counter

This block measures how fast the main clock runs by counting its cycles across a fixed window of a slower reference clock. The slow clock is sampled into the main-clock domain through a two-flop synchronizer, and its edges are detected there. Everything else runs on the main clock: the trigger detection, the window sequencer and the cycle counter.

A measurement is started by one of three events. The first is the RC oscillator reporting stable while it is the selected main source. The second is the crystal oscillator reporting stable while it is the selected main source. The third is any change of the source selection. A start clears the result and drops the ready flag. The counter then waits for the next slow rising edge. It counts main-clock cycles until the sixteenth slow falling edge after that rising edge. At that point it stops, sets ready, and holds the count for reading.

A new trigger that arrives while a measurement is running abandons that measurement and starts the whole sequence again. Software can turn the held count into a frequency: multiply the count by the slow-clock frequency and divide by the window length in slow periods.

Top module: `freq_meter`

## Requirements
- R1: While reset is asserted and right after it, `ready_o` is 0 and `count_o` is 0.
- R2: A 0-to-1 change of `rc_stable` while `src_sel` is 0 (0 selects the RC source) starts a measurement.
- R3: A 0-to-1 change of `xtal_stable` while `src_sel` is 1 (1 selects the crystal source) starts a measurement. The same change while `src_sel` is 0 has no effect: `ready_o` and `count_o` keep their values.
- R4: Any change of `src_sel`, in either direction, starts a measurement.
- R5: The result is the number of main-clock cycles from the first synchronized slow rising edge after a start to the 16th synchronized slow falling edge after it. For a 50% duty slow clock of P main cycles, the result is 15·P + P/2.
- R6: When counting stops, `ready_o` goes to 1. Until the next start, `ready_o` stays 1 and `count_o` does not change.
- R7: On the clock edge that takes a start, `ready_o` goes to 0 and `count_o` goes to 0.
- R8: `count_o` is 16 bits wide and saturates at 65535 rather than wrapping.
- R9: A start during a running measurement abandons it. The count is cleared, `ready_o` stays 0, and the result reported afterwards covers only the restarted window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock being measured; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_slow | input | 1 | Slow reference clock, asynchronous to clk_main |
| src_sel | input | 1 | Main source selection: 0 = RC, 1 = crystal |
| rc_stable | input | 1 | RC oscillator stable indication |
| xtal_stable | input | 1 | Crystal oscillator stable indication |
| count_o | output | 16 | Measured main-clock cycle count |
| ready_o | output | 1 | Measurement complete, count valid and held |

## Verification
Suppose the falling-edge tally or the window state is wrong. The fault shows up only at the next ready rise, as a count off by multiples of half a slow period, or as a ready that never comes. So the counts are compared exactly at each completion, using slow periods of 30 and 32 main cycles. A wrongly detected trigger shows one cycle after the input event: ready fails to drop, or drops when it should not. A counter that wraps shows only in a window long enough to pass 65535.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2,
    ST_DONE  = 2'd3
  } fm_state_e;
endpackage

// File: rtl/fm_rst_sync.sv
module fm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = shift_q[STAGES-1];
endmodule

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              level_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~level_q;
  assign fall_o = ~chain_q[STAGES-1] & level_q;
endmodule

// File: rtl/fm_trigger.sv
module fm_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic rc_stable,
  input  logic xtal_stable,
  output logic trig_o
);
  logic sel_q, rc_q, xt_q;
  logic rc_rise, xt_rise, sel_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      rc_q  <= 1'b0;
      xt_q  <= 1'b0;
    end else begin
      sel_q <= src_sel;
      rc_q  <= rc_stable;
      xt_q  <= xtal_stable;
    end
  end

  always_comb begin
    rc_rise  = rc_stable & ~rc_q & ~src_sel;
    xt_rise  = xtal_stable & ~xt_q & src_sel;
    sel_flip = src_sel ^ sel_q;
    trig_o   = rc_rise | xt_rise | sel_flip;
  end
endmodule

// File: rtl/fm_window_ctrl.sv
module fm_window_ctrl
  import freq_meter_pkg::*;
#(
  parameter int WIN_EDGES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic cnt_clr_o,
  output logic cnt_en_o,
  output logic ready_o
);
  localparam int EW = $clog2(WIN_EDGES + 1);
  localparam logic [EW-1:0] LAST = EW'(WIN_EDGES - 1);

  fm_state_e       state_q, state_d;
  logic [EW-1:0]   edges_q, edges_d;
  logic            ready_q, ready_d;

  always_comb begin
    state_d = state_q;
    edges_d = edges_q;
    ready_d = ready_q;
    if (trig_i) begin
      state_d = ST_ARM;
      edges_d = '0;
      ready_d = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: ;
        ST_ARM: begin
          if (rise_i) state_d = ST_COUNT;
        end
        ST_COUNT: begin
          if (fall_i) begin
            if (edges_q == LAST) begin
              state_d = ST_DONE;
              ready_d = 1'b1;
            end else begin
              edges_d = edges_q + EW'(1);
            end
          end
        end
        ST_DONE: ;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edges_q <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      edges_q <= edges_d;
      ready_q <= ready_d;
    end
  end

  assign cnt_clr_o = trig_i;
  assign cnt_en_o  = (state_q == ST_COUNT);
  assign ready_o   = ready_q;
endmodule

// File: rtl/fm_sat_counter.sv
module fm_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] value_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] value_q, value_d;
  logic         load;

  always_comb begin
    load    = clr_i | (en_i & (value_q != MAXV));
    value_d = clr_i ? '0 : value_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value_q <= '0;
    else if (load) value_q <= value_d;
  end

  assign value_o = value_q;
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int CNT_W       = 16,
  parameter int WIN_EDGES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_main,
  input  logic             rst_n,
  input  logic             clk_slow,
  input  logic             src_sel,
  input  logic             rc_stable,
  input  logic             xtal_stable,
  output logic [CNT_W-1:0] count_o,
  output logic             ready_o
);
  logic rst_int_n;
  logic slow_rise, slow_fall;
  logic trig;
  logic cnt_clr, cnt_en;

  fm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk_main),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  fm_edge_sync #(.STAGES(SYNC_STAGES)) u_slow (
    .clk     (clk_main),
    .rst_n   (rst_int_n),
    .async_i (clk_slow),
    .rise_o  (slow_rise),
    .fall_o  (slow_fall)
  );

  fm_trigger u_trig (
    .clk         (clk_main),
    .rst_n       (rst_int_n),
    .src_sel     (src_sel),
    .rc_stable   (rc_stable),
    .xtal_stable (xtal_stable),
    .trig_o      (trig)
  );

  fm_window_ctrl #(.WIN_EDGES(WIN_EDGES)) u_ctrl (
    .clk       (clk_main),
    .rst_n     (rst_int_n),
    .trig_i    (trig),
    .rise_i    (slow_rise),
    .fall_i    (slow_fall),
    .cnt_clr_o (cnt_clr),
    .cnt_en_o  (cnt_en),
    .ready_o   (ready_o)
  );

  fm_sat_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk_main),
    .rst_n   (rst_int_n),
    .clr_i   (cnt_clr),
    .en_i    (cnt_en),
    .value_o (count_o)
  );
endmodule

// File: rtl/freq_meter_chk.sv
module freq_meter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_sel,
  input logic             rc_stable,
  input logic             trig,
  input logic [CNT_W-1:0] count_o,
  input logic             ready_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  AST_RC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rc_stable) && !src_sel) |-> trig); // R2
  AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != $past(src_sel)) |-> trig); // R4
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (!ready_o && count_o == '0)); // R7
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !trig) |=> $stable(count_o)); // R6
  AST_HOLD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !trig) |=> ready_o); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == MAXV && !trig) |=> count_o == MAXV); // R8
  AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> count_o >= $past(count_o)); // R5
endmodule

bind freq_meter freq_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk_main),
  .rst_n     (rst_int_n),
  .src_sel   (src_sel),
  .rc_stable (rc_stable),
  .trig      (trig),
  .count_o   (count_o),
  .ready_o   (ready_o)
);

// File: tb/sim_freq_meter.sv
`timescale 1ns/1ps
module sim_freq_meter;
  logic        clk_main, rst_n, clk_slow;
  logic        src_sel, rc_stable, xtal_stable;
  logic [15:0] count_o;
  logic        ready_o;

  int    n_checks = 0;
  int    n_err    = 0;
  int    exp_q[$];
  string req_q[$];
  realtime slow_half = 160.0;
  logic  ready_prev = 1'b0;
  bit    finished = 1'b0;

  freq_meter u0 (
    .clk_main    (clk_main),
    .rst_n       (rst_n),
    .clk_slow    (clk_slow),
    .src_sel     (src_sel),
    .rc_stable   (rc_stable),
    .xtal_stable (xtal_stable),
    .count_o     (count_o),
    .ready_o     (ready_o)
  );

  initial begin
    clk_main = 1'b0;
    forever #5 clk_main = ~clk_main;
  end

  initial begin
    clk_slow = 1'b0;
    #3;
    forever #(slow_half) clk_slow = ~clk_slow;
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  task automatic expect_result(int value, string req);
    exp_q.push_back(value);
    req_q.push_back(req);
  endtask

  task automatic wait_ready(string req, int limit);
    int waited = 0;
    @(negedge clk_main);
    while (!ready_o && waited < limit) begin
      @(negedge clk_main);
      waited++;
    end
    if (!ready_o) check({req, " ready timeout"}, 0, 1);
  endtask

  // Monitor: compares each completed measurement against the scoreboard
  initial begin
    forever begin
      @(negedge clk_main);
      if (ready_o && !ready_prev) begin
        if (exp_q.size() == 0) begin
          check("R6 unexpected completion", 1, 0);
        end else begin
          check({req_q.pop_front(), " result"}, int'(count_o), exp_q.pop_front());
        end
      end
      ready_prev = ready_o;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_main);
    check("watchdog expired", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; src_sel = 1'b0; rc_stable = 1'b0; xtal_stable = 1'b0;
    repeat (5) @(negedge clk_main);
    check("R1 ready in reset", int'(ready_o), 0);
    check("R1 count in reset", int'(count_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_main);
    check("R1 ready after reset", int'(ready_o), 0);

    // R2: RC becomes stable while RC selected, P = 32 cycles
    rc_stable = 1'b1;
    expect_result(32 * 15 + 16, "R2/R5");
    @(negedge clk_main);
    check("R7 ready cleared on start", int'(ready_o), 0);
    check("R7 count cleared on start", int'(count_o), 0);
    wait_ready("R2", 5000);

    // R6: held while ready
    repeat (100) @(negedge clk_main);
    check("R6 count held", int'(count_o), 496);
    check("R6 ready held", int'(ready_o), 1);

    // R3: crystal stable while RC selected is ignored
    xtal_stable = 1'b1;
    repeat (60) @(negedge clk_main);
    check("R3 ignored ready", int'(ready_o), 1);
    check("R3 ignored count", int'(count_o), 496);

    // R4: selection change, P = 30 cycles
    slow_half = 150.0;
    repeat (3) @(posedge clk_slow);
    @(negedge clk_main);
    src_sel = 1'b1;
    expect_result(30 * 15 + 15, "R4/R5");
    @(negedge clk_main);
    check("R4 ready dropped on select change", int'(ready_o), 0);
    wait_ready("R4", 5000);

    // R3: crystal becomes stable while crystal selected
    @(negedge clk_main);
    xtal_stable = 1'b0;
    repeat (5) @(negedge clk_main);
    xtal_stable = 1'b1;
    expect_result(465, "R3");
    @(negedge clk_main);
    check("R3 ready dropped on crystal stable", int'(ready_o), 0);
    wait_ready("R3", 5000);

    // R9: restart during a running measurement
    @(negedge clk_main);
    xtal_stable = 1'b0;
    repeat (3) @(negedge clk_main);
    xtal_stable = 1'b1;
    repeat (200) @(negedge clk_main);
    check("R9 still running", int'(ready_o), 0);
    check("R9 counting mid-window", int'(count_o != 0), 1);
    xtal_stable = 1'b0;
    @(negedge clk_main);
    xtal_stable = 1'b1;
    expect_result(465, "R9");
    @(negedge clk_main);
    check("R9 count cleared on restart", int'(count_o), 0);
    check("R9 ready low on restart", int'(ready_o), 0);
    wait_ready("R9", 5000);

    // R8: long window saturates, P = 4500 cycles
    slow_half = 22500.0;
    repeat (3) @(posedge clk_slow);
    @(negedge clk_main);
    src_sel = 1'b0;
    expect_result(65535, "R8");
    wait_ready("R8", 100000);
    repeat (20) @(negedge clk_main);
    check("R8 saturated value held", int'(count_o), 65535);

    check("R5 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule